// File: doc/BRIEF.md
# Fractional-Rate Pulse-Swallowing Divider

This block takes a stream of single-cycle event strobes, sampled on the system clock, and lets 16 of every 25 events through. The average output rate is therefore 16/25 of the input rate. Placed after a divide-by-64 stage, the pair divides by exactly 100. Nothing is said about how evenly the passed events are spaced. The block only fixes which positions within each 25-event frame are dropped.

Two drop patterns are offered. In burst mode, a modulo-25 event count passes positions 0 to 15 and drops positions 16 to 24. The drop decision comes straight from the high bit of the count. In spread mode, two identical modulo-5 stages are chained. Each stage drops one event in five, and the second stage sees only the events the first one let through. The gaps are therefore spread across the frame.

A frame-start strobe marks the passed event at position 0 of each frame. A synchronous clear returns every count to zero. A change on the mode input is taken up only by the first event of a frame.

Top module: `frac_swallow_div`

## Requirements
- R1: In every complete frame of 25 counted events, exactly 16 events appear on `ev_out` and 9 are dropped. This holds in either mode.
- R2: In burst mode (`mode_sel`=0), the events at frame positions 0 to 15 are passed and those at positions 16 to 24 are dropped. Positions count from 0.
- R3: In spread mode (`mode_sel`=1), the events at frame positions 4, 5, 9, 11, 14, 17, 19, 23 and 24 are dropped and all others are passed. Positions count from 0.
- R4: `ev_out` is high in the cycle after a clock edge that sampled a passed event. It is never high in a cycle that was not preceded by a counted event.
- R5: `frame_start` is high together with `ev_out` for the event at frame position 0, and is low at all other times.
- R6: While `clr` is high at a clock edge, every count returns to position 0 and both outputs are low in the next cycle. An event that coincides with `clr` is not counted and not passed. The first event after a clear is passed at frame position 0.
- R7: Cycles without an event leave the frame position unchanged, whatever the number of idle cycles between events.
- R8: The mode is taken from `mode_sel` only with the event at frame position 0. A change of `mode_sel` within a frame has no effect until the next frame.
- R9: Over 2500 consecutive events, 1600 are passed, so a divide-by-64 stage in front gives an overall ratio of exactly 100.
- R10: After reset, both outputs are low and the first event is passed with `frame_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear of all counts; takes priority over `ev_in` |
| mode_sel | input | 1 | Requested pattern: 0 burst, 1 spread |
| ev_in | input | 1 | Single-cycle input event strobe |
| ev_out | output | 1 | Registered strobe for each passed event |
| frame_start | output | 1 | Registered strobe for the passed event at frame position 0 |

## Verification
The assertions assume the following about the inputs:
- Each input event lasts one clock.
- `clr` and `mode_sel` are synchronous to `clk`.
- No checking is intended in the two cycles after reset, while the reset synchroniser releases.

The stimulus drives every input at the falling edge and waits out the synchroniser after reset before the first event. It uses strobes of any spacing from back-to-back to several idle cycles, which covers the idle-hold rule without ever holding an event across a frame boundary by accident. Mode toggles and clears are placed at every frame position in both modes.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic {
    MODE_BURST  = 1'b0,
    MODE_SPREAD = 1'b1
  } fsd_mode_e;

  function automatic int unsigned ipow(input int unsigned base, input int unsigned expn);
    int unsigned acc;
    acc = 1;
    for (int unsigned i = 0; i < expn; i++) begin
      acc = acc * base;
    end
    return acc;
  endfunction

endpackage

// File: rtl/fsd_rst_sync.sv
module fsd_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;

endmodule

// File: rtl/fsd_burst_ctr.sv
module fsd_burst_ctr #(
  parameter int unsigned FRAME = 25,
  parameter int unsigned PASS  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic pass,
  output logic at_zero
);

  localparam int unsigned CW = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);
  localparam bit POW2_TAIL = ((PASS & (PASS - 1)) == 0) && (FRAME <= 2 * PASS) && (PASS > 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          drop;

  // The drop flag comes from a single count bit when the pass length
  // is a power of two that covers the upper part of the frame.
  generate
    if (POW2_TAIL) begin : g_bit_drop
      localparam int unsigned DB = $clog2(PASS);
      assign drop = cnt_q[DB];
    end else begin : g_cmp_drop
      assign drop = (cnt_q >= CW'(PASS));
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pass    = ~drop;
  assign at_zero = (cnt_q == '0);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && cnt_q == LAST) |=> (cnt_q == '0));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt_q));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LAST));

endmodule

// File: rtl/fsd_mod_stage.sv
module fsd_mod_stage #(
  parameter int unsigned MOD = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic pass,
  output logic at_zero
);

  localparam int unsigned SW = (MOD > 1) ? $clog2(MOD) : 1;
  localparam logic [SW-1:0] LAST = SW'(MOD - 1);

  logic [SW-1:0] cnt_q;
  logic [SW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The event arriving on the last count value is swallowed.
  assign pass    = (cnt_q != LAST);
  assign at_zero = (cnt_q == '0);

  a_r3_stage_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && cnt_q == LAST) |=> (cnt_q == '0));

  a_r3_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LAST));

  a_r7_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt_q));

  a_r6_stage_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/frac_swallow_div.sv
module frac_swallow_div
  import fsd_pkg::*;
#(
  parameter int unsigned STAGE_MOD  = 5,
  parameter int unsigned NUM_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic mode_sel,
  input  logic ev_in,
  output logic ev_out,
  output logic frame_start
);

  localparam int unsigned FRAME = ipow(STAGE_MOD, NUM_STAGES);
  localparam int unsigned PASS  = ipow(STAGE_MOD - 1, NUM_STAGES);

  logic rst_s_n;

  fsd_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s_n)
  );

  fsd_mode_e mode_q;
  fsd_mode_e mode_d;
  fsd_mode_e eff_mode;
  logic      at_boundary;
  logic      ev_take;

  logic burst_adv;
  logic burst_pass;
  logic burst_zero;

  logic [NUM_STAGES:0]   chain;
  logic [NUM_STAGES-1:0] st_pass;
  logic [NUM_STAGES-1:0] st_zero;

  logic pass_now;
  logic ev_out_q;
  logic ev_out_d;
  logic fs_q;
  logic fs_d;

  assign ev_take     = ev_in & ~clr;
  assign at_boundary = burst_zero & (&st_zero);
  assign eff_mode    = at_boundary ? fsd_mode_e'(mode_sel) : mode_q;

  assign burst_adv = ev_take & (eff_mode == MODE_BURST);

  fsd_burst_ctr #(
    .FRAME (FRAME),
    .PASS  (PASS)
  ) u_burst (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr     (clr),
    .adv     (burst_adv),
    .pass    (burst_pass),
    .at_zero (burst_zero)
  );

  assign chain[0] = ev_take & (eff_mode == MODE_SPREAD);

  generate
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
      fsd_mod_stage #(
        .MOD (STAGE_MOD)
      ) u_stage (
        .clk     (clk),
        .rst_n   (rst_s_n),
        .clr     (clr),
        .adv     (chain[g]),
        .pass    (st_pass[g]),
        .at_zero (st_zero[g])
      );
      assign chain[g+1] = chain[g] & st_pass[g];
    end
  endgenerate

  always_comb begin
    if (eff_mode == MODE_BURST) pass_now = burst_adv & burst_pass;
    else                        pass_now = chain[NUM_STAGES];
  end

  always_comb begin
    ev_out_d = pass_now;
    fs_d     = pass_now & at_boundary;
    mode_d   = eff_mode;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ev_out_q <= 1'b0;
      fs_q     <= 1'b0;
      mode_q   <= MODE_BURST;
    end else begin
      ev_out_q <= ev_out_d;
      fs_q     <= fs_d;
      mode_q   <= mode_d;
    end
  end

  assign ev_out      = ev_out_q;
  assign frame_start = fs_q;

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(ev_in && !clr) |=> !ev_out);

  a_r5_fs_with_out: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_start |-> ev_out);

  a_r6_quiet_after_clr: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr |=> (!ev_out && !frame_start));

  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !at_boundary |=> $stable(mode_q));

  a_r5_start_passes: assert property (@(posedge clk) disable iff (!rst_s_n)
    (at_boundary && ev_in && !clr) |=> (ev_out && frame_start));

endmodule

// File: tb/tb_frac_swallow_div.sv
`timescale 1ns/1ps
module tb_frac_swallow_div;

  logic clk;
  logic rst_n;
  logic clr;
  logic mode_sel;
  logic ev_in;
  logic ev_out;
  logic frame_start;

  int n_checks;
  int n_fail;
  bit done;

  // bench model
  int  pos;
  bit  cur_mode;
  int  frame_tally;
  bit  tally_valid;
  int  total_out;

  frac_swallow_div dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .mode_sel    (mode_sel),
    .ev_in       (ev_in),
    .ev_out      (ev_out),
    .frame_start (frame_start)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit pass_at(input bit m, input int p);
    int a;
    int k;
    if (!m) return (p < 16);
    a = p % 5;
    if (a == 4) return 1'b0;
    k = (p / 5) * 4 + a;
    return ((k % 5) != 4);
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at falling edge, sample at next falling edge
  task automatic step(input bit ev, input bit c, input bit m);
    bit    eo;
    bit    ef;
    bit    wrapped;
    string tag;
    ev_in    = ev;
    clr      = c;
    mode_sel = m;
    eo = 1'b0;
    ef = 1'b0;
    wrapped = 1'b0;
    if (c) begin
      tag = "R6";
      pos = 0;
      frame_tally = 0;
      tally_valid = 1'b1;
    end else if (ev) begin
      if (pos == 0) cur_mode = m;
      eo  = pass_at(cur_mode, pos);
      ef  = eo && (pos == 0);
      tag = (m != cur_mode) ? "R8" : (cur_mode ? "R3" : "R2");
      pos = (pos + 1) % 25;
      wrapped = (pos == 0);
    end else begin
      tag = "R7";
    end
    @(negedge clk);
    check(ev_out == eo, tag, int'(ev_out), int'(eo));
    check(frame_start == ef, "R5", int'(frame_start), int'(ef));
    if (ev_out) begin
      frame_tally++;
      total_out++;
    end
    if (wrapped) begin
      if (tally_valid) check(frame_tally == 16, "R1", frame_tally, 16);
      frame_tally = 0;
      tally_valid = 1'b1;
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    pos = 0;
    cur_mode = 1'b0;
    frame_tally = 0;
    tally_valid = 1'b1;
    total_out = 0;
    rst_n = 1'b0;
    clr = 1'b0;
    mode_sel = 1'b0;
    ev_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state and first event passes
    check(ev_out == 1'b0, "R10", int'(ev_out), 0);
    check(frame_start == 1'b0, "R10", int'(frame_start), 0);
    step(1'b1, 1'b0, 1'b0);
    check(ev_out && frame_start, "R10", int'(ev_out), 1);

    // R2, R1, R7: burst frames with varying idle gaps
    for (int i = 0; i < 24 * 4 + 20; i++) begin
      step(1'b1, 1'b0, 1'b0);
      for (int g = 0; g < (i % 4); g++) step(1'b0, 1'b0, 1'b0);
    end

    // R3, R1, R7: spread frames, reach frame boundary first via clear
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 25 * 4; i++) begin
      step(1'b1, 1'b0, 1'b1);
      for (int g = 0; g < (i % 3); g++) step(1'b0, 1'b0, 1'b1);
    end

    // R8: toggle mode_sel every 7 events
    for (int i = 0; i < 25 * 8; i++) begin
      step(1'b1, 1'b0, ((i / 7) % 2) == 1);
    end

    // R6: clear at every position in both modes, with and without event
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 25; p++) begin
        step(1'b0, 1'b1, m[0]);
        for (int e = 0; e < p; e++) step(1'b1, 1'b0, m[0]);
        step(1'b1, 1'b1, m[0]);
        step(1'b1, 1'b0, m[0]);
        check(ev_out && frame_start, "R6", int'(ev_out), 1);
      end
    end

    // R9: 2500 back-to-back events from a frame boundary
    for (int m = 0; m < 2; m++) begin
      step(1'b0, 1'b1, m[0]);
      total_out = 0;
      for (int e = 0; e < 2500; e++) step(1'b1, 1'b0, m[0]);
      check(total_out == 1600, "R9", total_out, 1600);
      check((64 * 2500) == (100 * total_out), "R9", 64 * 2500 / (total_out == 0 ? 1 : total_out), 100);
    end

    ev_in = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule